// File: doc/BRIEF.md
# LIN Break and Auto-Baud Detector

This block listens to the receive line of a LIN slave. The line idles high. The block looks for a long dominant (low) break followed by a recessive delimiter. It then timestamps the falling edges of the 0x55 synch byte to recover the master's bit period. Every edge time comes from a free-running timestamp counter that is sampled at the edge. Because of this, the measured intervals are exact whole reference-clock counts, and the latency of the decision logic adds no error.

A frame header is accepted only after three checks. The measured period must fall inside one of three nominal rate windows. The break must be at least 11 of those periods long. The delimiter must be at least one period long. An accepted header updates `bit_period` and fires `baud_ok` for one cycle. A rejected header fires `sync_err` for one cycle and returns the machine to idle. A separate watch counter raises `bus_idle` when no qualified break has arrived for a long time. `bus_idle` is a status flag, not an error.

The machine has five states:
- `ST_IDLE` goes to `ST_BREAK` on a falling edge.
- `ST_BREAK` goes to `ST_DELIM` on a rising edge if the low phase reached `BRK_MIN`. On a shorter low phase it goes back to `ST_IDLE` silently. If the line stays low until the gap limit, it goes to `ST_IDLE` with an error.
- `ST_DELIM` goes to `ST_SYNCH` on the next falling edge, which is the synch start bit. On a gap timeout it goes to `ST_IDLE` with an error.
- `ST_SYNCH` counts falling edges and goes to `ST_JUDGE` on the fifth. On a gap timeout it goes to `ST_IDLE` with an error.
- `ST_JUDGE` runs the checks and always returns to `ST_IDLE`.

Top module: `lin_sync_detect`

## Requirements
- R1: After reset, and on every cycle after a cycle with `en` low, `baud_ok`, `sync_err` and `bus_idle` are 0. `bit_period` resets to 0. A header sent while `en` is low produces no pulse and leaves `bit_period` unchanged.
- R2: A low phase shorter than `BRK_MIN` cycles is ignored. It produces neither `baud_ok` nor `sync_err`.
- R3: For an accepted header, `bit_period` equals (time of 5th synch falling edge − time of 1st synch falling edge) >> 3, in reference-clock cycles. It appears together with a single `baud_ok` pulse within 8 cycles after the 5th falling edge. `bit_period` changes at no other time.
- R4: The period is accepted only when it lies within [N*85/100, N*115/100] (integer division) for N in {`NOM_FAST`, `NOM_MID`, `NOM_SLOW`}. Otherwise `sync_err` pulses and `bit_period` keeps its old value.
- R5: A qualified break shorter than 11 times the measured period causes `sync_err`, with no `baud_ok`.
- R6: A delimiter (rising edge to the synch start edge) shorter than the measured period causes `sync_err`, with no `baud_ok`.
- R7: If no edge arrives for `GAP_MAX` cycles while in break, delimiter or synch, `sync_err` pulses once and the block returns to idle.
- R8: `bus_idle` rises once `IDLE_LIMIT` cycles pass with `en` high and no qualified break. It falls at the next qualified break.
- R9: `baud_ok` and `sync_err` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the timestamp counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Detector enable; low holds the machine in idle |
| rx_in | input | 1 | Bus receive line, high when recessive |
| bit_period | output | TS_W | Last accepted bit period in clock cycles |
| baud_ok | output | 1 | One-cycle strobe: new period accepted |
| sync_err | output | 1 | One-cycle strobe: header rejected |
| bus_idle | output | 1 | No qualified break for `IDLE_LIMIT` cycles |

## Verification
The assertions assume that `rx_in` changes no faster than the synchronizer can follow. They also assume that every interval worth measuring is shorter than the timestamp wrap of 2^`TS_W` cycles, which `GAP_MAX` bounds. The stimulus changes `rx_in` only on falling clock edges and in whole-cycle steps, so each edge is seen once. It sizes every break, delimiter and synch bit well under `GAP_MAX`, except in the two timeout scenarios. The stimulus also drives `en` low only between headers.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_DELIM,
        ST_SYNCH,
        ST_JUDGE
    } sync_state_t;
endpackage

// File: rtl/lin_rx_edge.sv
// Two-flop synchronizer plus registered edge detection on the receive line.
module lin_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic fall,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rx_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign fall = prev_q & ~sync_q;
    assign rise = ~prev_q & sync_q;
endmodule

// File: rtl/lin_stamp_timer.sv
// Free-running timestamp counter; wraps modulo 2^W.
module lin_stamp_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] stamp
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stamp <= '0;
        else        stamp <= stamp + W'(1);
    end
endmodule

// File: rtl/lin_rate_window.sv
// Tolerance windows around each nominal bit period.
module lin_rate_window #(
    parameter int unsigned W        = 16,
    parameter int unsigned NOM_FAST = 417,
    parameter int unsigned NOM_MID  = 833,
    parameter int unsigned NOM_SLOW = 3333
) (
    input  logic [W-1:0] period,
    output logic         hit
);
    localparam int unsigned NRATES = 3;
    logic [NRATES-1:0] hits;

    for (genvar g = 0; g < NRATES; g++) begin : g_win
        localparam int unsigned NOM = (g == 0) ? NOM_FAST : (g == 1) ? NOM_MID : NOM_SLOW;
        localparam int unsigned LO  = (NOM * 85) / 100;
        localparam int unsigned HI  = (NOM * 115) / 100;
        assign hits[g] = (period >= W'(LO)) && (period <= W'(HI));
    end

    assign hit = |hits;
endmodule

// File: rtl/lin_idle_watch.sv
// Counts enabled cycles since the last qualified break and flags a quiet bus.
module lin_idle_watch #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic quiet
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            quiet <= 1'b0;
        end else if (!en || clr) begin
            cnt   <= '0;
            quiet <= 1'b0;
        end else begin
            if (cnt != CW'(LIMIT)) cnt <= cnt + CW'(1);
            quiet <= (cnt == CW'(LIMIT));
        end
    end
endmodule

// File: rtl/lin_sync_detect.sv
module lin_sync_detect
    import lin_sync_pkg::*;
#(
    parameter int unsigned TS_W       = 16,
    parameter int unsigned NOM_FAST   = 417,
    parameter int unsigned NOM_MID    = 833,
    parameter int unsigned NOM_SLOW   = 3333,
    parameter int unsigned BRK_MIN    = (11 * NOM_FAST * 85) / 100,
    parameter int unsigned GAP_MAX    = 60000,
    parameter int unsigned IDLE_LIMIT = 25000 * NOM_SLOW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            rx_in,
    output logic [TS_W-1:0] bit_period,
    output logic            baud_ok,
    output logic            sync_err,
    output logic            bus_idle
);
    localparam int unsigned XW       = TS_W + 4;
    localparam int unsigned SYNC_FALLS = 5;
    localparam int unsigned EC_W     = $clog2(SYNC_FALLS + 1);

    sync_state_t     st, nxt;
    logic            fall, rise;
    logic [TS_W-1:0] stamp, t_mark, brk_len, dlm_len, span, gap, since;
    logic [EC_W-1:0] edge_cnt;
    logic [TS_W-1:0] per;
    logic [XW-1:0]   per11;
    logic            rate_hit, accept, tmo, brk_good, gap_hit;

    lin_rx_edge u_edge (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .fall(fall), .rise(rise)
    );

    lin_stamp_timer #(.W(TS_W)) u_stamp (
        .clk(clk), .rst_n(rst_n), .stamp(stamp)
    );

    lin_rate_window #(
        .W(TS_W), .NOM_FAST(NOM_FAST), .NOM_MID(NOM_MID), .NOM_SLOW(NOM_SLOW)
    ) u_win (
        .period(per), .hit(rate_hit)
    );

    lin_idle_watch #(.LIMIT(IDLE_LIMIT)) u_idle (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(brk_good), .quiet(bus_idle)
    );

    assign since   = stamp - t_mark;
    assign gap_hit = (gap == TS_W'(GAP_MAX));
    assign per     = span >> 3;
    assign per11   = {4'b0, per} * XW'(11);
    assign accept  = rate_hit && ({4'b0, brk_len} >= per11) && (dlm_len >= per);

    // next-state logic
    always_comb begin
        nxt      = st;
        tmo      = 1'b0;
        brk_good = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (fall) nxt = ST_BREAK;
            end
            ST_BREAK: begin
                if (rise) begin
                    if (since >= TS_W'(BRK_MIN)) begin
                        nxt      = ST_DELIM;
                        brk_good = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end else if (gap_hit) begin
                    nxt = ST_IDLE;
                    tmo = 1'b1;
                end
            end
            ST_DELIM: begin
                if (fall) nxt = ST_SYNCH;
                else if (gap_hit) begin
                    nxt = ST_IDLE;
                    tmo = 1'b1;
                end
            end
            ST_SYNCH: begin
                if (fall && edge_cnt == EC_W'(SYNC_FALLS - 1)) nxt = ST_JUDGE;
                else if (gap_hit) begin
                    nxt = ST_IDLE;
                    tmo = 1'b1;
                end
            end
            ST_JUDGE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        if (!en) begin
            nxt      = ST_IDLE;
            tmo      = 1'b0;
            brk_good = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // timestamp captures and edge/gap counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_mark   <= '0;
            brk_len  <= '0;
            dlm_len  <= '0;
            span     <= '0;
            edge_cnt <= '0;
            gap      <= '0;
        end else begin
            if (fall || rise || st == ST_IDLE) gap <= '0;
            else if (!gap_hit)                 gap <= gap + TS_W'(1);
            unique case (st)
                ST_IDLE:  if (fall) t_mark <= stamp;
                ST_BREAK: if (rise) begin
                    brk_len <= since;
                    t_mark  <= stamp;
                end
                ST_DELIM: if (fall) begin
                    dlm_len  <= since;
                    t_mark   <= stamp;
                    edge_cnt <= EC_W'(1);
                end
                ST_SYNCH: if (fall) begin
                    edge_cnt <= edge_cnt + EC_W'(1);
                    span     <= since;
                end
                ST_JUDGE: ;
                default:  ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_period <= '0;
            baud_ok    <= 1'b0;
            sync_err   <= 1'b0;
        end else if (!en) begin
            baud_ok  <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            baud_ok  <= (st == ST_JUDGE) && accept;
            sync_err <= tmo || ((st == ST_JUDGE) && !accept);
            if (st == ST_JUDGE && accept) bit_period <= per;
        end
    end
endmodule

// File: rtl/lin_sync_detect_chk.sv
module lin_sync_detect_chk #(
    parameter int unsigned TS_W     = 16,
    parameter int unsigned NOM_FAST = 417,
    parameter int unsigned NOM_MID  = 833,
    parameter int unsigned NOM_SLOW = 3333
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic [TS_W-1:0] bit_period,
    input logic            baud_ok,
    input logic            sync_err,
    input logic            bus_idle
);
    function automatic logic in_any(input logic [TS_W-1:0] p);
        in_any = ((p >= TS_W'((NOM_FAST * 85) / 100)) && (p <= TS_W'((NOM_FAST * 115) / 100))) ||
                 ((p >= TS_W'((NOM_MID  * 85) / 100)) && (p <= TS_W'((NOM_MID  * 115) / 100))) ||
                 ((p >= TS_W'((NOM_SLOW * 85) / 100)) && (p <= TS_W'((NOM_SLOW * 115) / 100)));
    endfunction

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(baud_ok && sync_err));

    // R9
    ok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_ok |=> !baud_ok);

    // R9
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> !sync_err);

    // R3
    period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_period) |-> baud_ok);

    // R4
    period_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_ok |-> in_any(bit_period));

    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!baud_ok && !sync_err && !bus_idle));
endmodule

bind lin_sync_detect lin_sync_detect_chk #(
    .TS_W(TS_W), .NOM_FAST(NOM_FAST), .NOM_MID(NOM_MID), .NOM_SLOW(NOM_SLOW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_period(bit_period),
    .baud_ok(baud_ok), .sync_err(sync_err), .bus_idle(bus_idle)
);

// File: tb/lin_sync_detect_tb_top.sv
module lin_sync_detect_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TS_W       = 16;
    localparam int NF         = 16;
    localparam int NM         = 32;
    localparam int NS         = 128;
    localparam int BMIN       = (11 * NF * 85) / 100;
    localparam int GMAX       = 2500;
    localparam int ILIM       = 20000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic            rx_in = 1'b1;
    logic [TS_W-1:0] bit_period;
    logic            baud_ok, sync_err, bus_idle;

    int total = 0;
    int bad = 0;
    int ok_cnt = 0;
    int err_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lin_sync_detect #(
        .TS_W(TS_W), .NOM_FAST(NF), .NOM_MID(NM), .NOM_SLOW(NS),
        .BRK_MIN(BMIN), .GAP_MAX(GMAX), .IDLE_LIMIT(ILIM)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .rx_in(rx_in),
        .bit_period(bit_period), .baud_ok(baud_ok),
        .sync_err(sync_err), .bus_idle(bus_idle)
    );

    always @(negedge clk) begin
        if (baud_ok)  ok_cnt++;
        if (sync_err) err_cnt++;
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int n);
        rx_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_hdr(input int brk, input int dlm, input int p);
        drive(1'b0, brk);
        drive(1'b1, dlm);
        drive(1'b0, p);
        for (int i = 0; i < 8; i++) drive(((8'h55 >> i) & 1) != 0, p);
        drive(1'b1, p);
        drive(1'b1, 20);
    endtask

    function automatic bit in_win(input int p);
        in_win = (p >= NF * 85 / 100 && p <= NF * 115 / 100) ||
                 (p >= NM * 85 / 100 && p <= NM * 115 / 100) ||
                 (p >= NS * 85 / 100 && p <= NS * 115 / 100);
    endfunction

    task automatic t_reset;
        chk(bit_period == 0, "R1 reset period", int'(bit_period), 0);
        chk(!baud_ok && !sync_err && !bus_idle, "R1 reset strobes",
            int'({baud_ok, sync_err, bus_idle}), 0);
    endtask

    // R3 / R4: good headers, accepted or rejected by the window
    task automatic t_rate(input int p, input string req);
        int o0 = ok_cnt, e0 = err_cnt, prev = int'(bit_period);
        send_hdr(13 * p, p, p);
        if (in_win(p)) begin
            chk(ok_cnt == o0 + 1 && err_cnt == e0, {req, " accept strobe"}, ok_cnt - o0, 1);
            chk(int'(bit_period) == p, {req, " period"}, int'(bit_period), p);
        end else begin
            chk(err_cnt == e0 + 1 && ok_cnt == o0, {req, " reject strobe"}, err_cnt - e0, 1);
            chk(int'(bit_period) == prev, {req, " period kept"}, int'(bit_period), prev);
        end
    endtask

    task automatic t_short_pulse;  // R2
        int o0 = ok_cnt, e0 = err_cnt;
        drive(1'b0, BMIN - 40);
        drive(1'b1, 200);
        chk(ok_cnt == o0 && err_cnt == e0, "R2 short low ignored", ok_cnt + err_cnt - o0 - e0, 0);
    endtask

    task automatic t_short_break;  // R5
        int o0 = ok_cnt, e0 = err_cnt;
        send_hdr(10 * NM, NM, NM);
        chk(err_cnt == e0 + 1 && ok_cnt == o0, "R5 short break", err_cnt - e0, 1);
    endtask

    task automatic t_short_delim;  // R6
        int o0 = ok_cnt, e0 = err_cnt;
        send_hdr(13 * NM, NM / 2, NM);
        chk(err_cnt == e0 + 1 && ok_cnt == o0, "R6 short delimiter", err_cnt - e0, 1);
    endtask

    task automatic t_stall;  // R7
        int e0 = err_cnt;
        drive(1'b0, 13 * NM);
        drive(1'b1, NM);
        drive(1'b0, NM);
        drive(1'b1, GMAX + 100);
        chk(err_cnt == e0 + 1, "R7 synch stall timeout", err_cnt - e0, 1);
    endtask

    task automatic t_stuck_low;  // R7
        int e0 = err_cnt;
        drive(1'b0, GMAX + 100);
        drive(1'b1, 100);
        chk(err_cnt == e0 + 1, "R7 stuck low timeout", err_cnt - e0, 1);
    endtask

    task automatic t_disabled;  // R1
        int o0 = ok_cnt, e0 = err_cnt, prev = int'(bit_period);
        en = 1'b0;
        drive(1'b1, 5);
        send_hdr(13 * NM, NM, NM + 1);
        chk(ok_cnt == o0 && err_cnt == e0, "R1 disabled no strobe", ok_cnt + err_cnt - o0 - e0, 0);
        chk(int'(bit_period) == prev, "R1 disabled period kept", int'(bit_period), prev);
        en = 1'b1;
        drive(1'b1, 2);
    endtask

    task automatic t_idle;  // R8
        drive(1'b1, ILIM - 200);
        chk(!bus_idle, "R8 not yet idle", int'(bus_idle), 0);
        drive(1'b1, 400);
        chk(bus_idle, "R8 idle flagged", int'(bus_idle), 1);
        send_hdr(13 * NM, NM, NM);
        chk(!bus_idle, "R8 idle cleared by break", int'(bus_idle), 0);
        chk(int'(bit_period) == NM, "R8 frame after idle", int'(bit_period), NM);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        en = 1'b1;
        drive(1'b1, 10);
        t_rate(NF, "R3 fast");
        t_rate(NM, "R3 mid");
        t_rate(NS, "R3 slow");
        t_rate(18, "R4 upper edge fast");
        t_rate(108, "R4 lower edge slow");
        t_rate(22, "R4 between windows");
        t_rate(12, "R4 below fast");
        t_short_pulse;
        t_short_break;
        t_short_delim;
        t_stall;
        t_stuck_low;
        t_disabled;
        t_idle;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule